// File: doc/BRIEF.md
# SDRAM Address and Mask Driver

This block sits on the controller side of a single-data-rate SDRAM port. Each clock it takes one request (idle, activate, read, write or precharge), a linear word address, a precharge-all flag, a data-beat descriptor and two byte enables. From these it produces registered values for the row/column address pins, the two bank-select pins, chip select, clock enable and the data-mask pins. The column width follows the parameter `ORG`, which selects a x16, x8 or x4 organisation. Read masks and write masks are aligned differently so that each mask meets the data beat it governs.

The beat descriptor always refers to the data beat that is on the DQ pins two cycles after the pin cycle that the request produces. A read mask has to be on the pins two cycles before its beat, so it goes out at once. A write mask has to be on the pins together with its beat, so it passes through a two-stage delay line. When clock enable is low on the pins, the next edge is treated as void, and every other output and the delay line hold.

Top module: `sdram_pin_driver`

## Requirements
- R1: While `rst_n` is low the outputs are `sd_addr`=0, `sd_bank`=0, `sd_cs_n`=1, `sd_cke`=1 and `sd_dqm`=2'b11, and the write-mask delay line is empty.
- R2: The `cmd` codes are 0 idle, 1 activate, 2 read, 3 write and 4 precharge. An activate accepted at an edge drives `sd_cs_n` low and puts the 12-bit row field on `sd_addr[11:0]` after that edge.
- R3: The linear address holds the column in its low COL_W bits, the bank in the next 2 bits and the row in the top 12 bits. On any non-idle command `sd_bank[0]` (first bank pin) carries the low bank bit and `sd_bank[1]` the high bit.
- R4: A read or write drives the column (the start address of the burst) on `sd_addr[COL_W-1:0]`, where COL_W is 8 for ORG=0 (x16), 9 for ORG=1 (x8) and 10 for ORG=2 (x4). All higher address pins, including `sd_addr[10]`, are low.
- R5: A precharge drives `sd_addr[10]` equal to `pre_all` (1 = all banks, 0 = the bank on `sd_bank`) and every other address pin low.
- R6: An idle request drives `sd_cs_n` high and leaves `sd_addr` and `sd_bank` at their previous values.
- R7: The `beat` codes are 0 none, 1 read and 2 write. A read beat puts its mask on `sd_dqm` in the pin cycle of the same request. A lane's mask bit is the inverse of its byte enable.
- R8: A write beat puts its mask on `sd_dqm` two accepted edges later than a read beat would.
- R9: `sd_dqm[0]` is the lower lane and `sd_dqm[1]` the upper lane. For ORG=0 each lane follows its own enable (`be[0]` lower, `be[1]` upper). For ORG=1 and ORG=2 both bits follow `be[0]`.
- R10: When a due write mask and a new read mask fall in the same pin cycle, the write mask wins. With neither present, `sd_dqm` is 2'b11.
- R11: `sd_cke` equals `cke_req` from the previous edge.
- R12: An edge at which `sd_cke` is low drops the request. `sd_addr`, `sd_bank`, `sd_cs_n` and `sd_dqm` keep their values, and the write-mask delay line does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd | input | 3 | Request code (0 idle, 1 activate, 2 read, 3 write, 4 precharge) |
| lin_addr | input | COL_W+14 | Linear word address {row, bank, column} |
| pre_all | input | 1 | Precharge all banks when set |
| beat | input | 2 | Beat descriptor (0 none, 1 read, 2 write) |
| be | input | 2 | Byte enables of the described beat |
| cke_req | input | 1 | Requested clock enable for the next pin cycle |
| sd_addr | output | 12 | Address pins A0..A11 |
| sd_bank | output | 2 | Bank-select pins, bit 0 low bank bit |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | 2 | Data mask, bit 0 lower lane, bit 1 upper lane |

## Verification
The bench builds three copies side by side, with ORG set to 0, 1 and 2, and drives all three from the same stimulus. Because the column widths are 8, 9 and 10, an all-ones address shows the column cut-off on each width and shows that the row and bank fields move with it. The x16 copy is the only one where the two mask lanes can differ. The x8 and x4 copies show the single-lane mirroring and let a read mask be told apart from a write mask in the collision case.

// File: rtl/sdram_drv_pkg.sv
package sdram_drv_pkg;

  localparam int ROW_W  = 12;
  localparam int BANK_W = 2;
  localparam int PIN_W  = 12;
  localparam int AP_POS = 10;
  localparam int LANES  = 2;

  typedef enum logic [2:0] {
    CMD_IDLE = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    BEAT_NONE = 2'd0,
    BEAT_RD   = 2'd1,
    BEAT_WR   = 2'd2
  } beat_e;

  typedef struct packed {
    logic [PIN_W-1:0]  a;
    logic [BANK_W-1:0] ba;
    logic              cs_n;
  } pins_t;

  // column bits per organisation: 0 -> x16, 1 -> x8, 2 -> x4
  function automatic int col_width(int org);
    case (org)
      0:       return 8;
      1:       return 9;
      default: return 10;
    endcase
  endfunction

  // active-high mask per lane from byte enables
  function automatic logic [LANES-1:0] lane_mask(bit wide, logic [LANES-1:0] en);
    if (wide) return ~en;
    return {LANES{~en[0]}};
  endfunction

endpackage

// File: rtl/sdram_addr_map.sv
module sdram_addr_map
  import sdram_drv_pkg::*;
#(
  parameter  int ORG   = 0,
  localparam int COL_W = col_width(ORG),
  localparam int LIN_W = COL_W + BANK_W + ROW_W
) (
  input  logic [2:0]       cmd,
  input  logic [LIN_W-1:0] lin_addr,
  input  logic             pre_all,
  input  pins_t            cur,
  output pins_t            nxt
);

  logic [COL_W-1:0]  col_f;
  logic [BANK_W-1:0] bank_f;
  logic [ROW_W-1:0]  row_f;
  cmd_e              c;

  assign col_f  = lin_addr[COL_W-1:0];
  assign bank_f = lin_addr[COL_W +: BANK_W];
  assign row_f  = lin_addr[COL_W+BANK_W +: ROW_W];
  assign c      = cmd_e'(cmd);

  always_comb begin
    nxt = cur;
    case (c)
      CMD_ACT: begin
        nxt.a    = PIN_W'(row_f);
        nxt.ba   = bank_f;
        nxt.cs_n = 1'b0;
      end
      CMD_RD, CMD_WR: begin
        nxt.a    = PIN_W'(col_f);
        nxt.ba   = bank_f;
        nxt.cs_n = 1'b0;
      end
      CMD_PRE: begin
        nxt.a         = '0;
        nxt.a[AP_POS] = pre_all;
        nxt.ba        = bank_f;
        nxt.cs_n      = 1'b0;
      end
      default: nxt.cs_n = 1'b1;
    endcase
  end

endmodule

// File: rtl/sdram_mask_align.sv
module sdram_mask_align
  import sdram_drv_pkg::*;
#(
  parameter int ORG    = 0,
  parameter int WR_LAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [1:0]       beat,
  input  logic [LANES-1:0] be,
  output logic [LANES-1:0] dqm_nxt,
  output logic             wr_due,
  output logic             rd_now
);

  localparam bit WIDE = (ORG == 0);

  logic [WR_LAG-1:0] lag_v;
  logic [LANES-1:0]  lag_m [WR_LAG];
  logic [LANES-1:0]  in_mask;

  assign in_mask = lane_mask(WIDE, be);

  for (genvar s = 0; s < WR_LAG; s++) begin : g_lag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lag_v[s] <= 1'b0;
        lag_m[s] <= '1;
      end else if (adv) begin
        if (s == 0) begin
          lag_v[s] <= (beat == BEAT_WR);
          lag_m[s] <= in_mask;
        end else begin
          lag_v[s] <= lag_v[s-1];
          lag_m[s] <= lag_m[s-1];
        end
      end
    end
  end

  assign wr_due = lag_v[WR_LAG-1];
  assign rd_now = (beat == BEAT_RD);

  always_comb begin
    if (wr_due)      dqm_nxt = lag_m[WR_LAG-1];
    else if (rd_now) dqm_nxt = in_mask;
    else             dqm_nxt = '1;
  end

endmodule

// File: rtl/sdram_pin_driver.sv
module sdram_pin_driver
  import sdram_drv_pkg::*;
#(
  parameter  int ORG   = 0,
  localparam int COL_W = col_width(ORG),
  localparam int LIN_W = COL_W + BANK_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd,
  input  logic [LIN_W-1:0]  lin_addr,
  input  logic              pre_all,
  input  logic [1:0]        beat,
  input  logic [LANES-1:0]  be,
  input  logic              cke_req,
  output logic [PIN_W-1:0]  sd_addr,
  output logic [BANK_W-1:0] sd_bank,
  output logic              sd_cs_n,
  output logic              sd_cke,
  output logic [LANES-1:0]  sd_dqm
);

  pins_t            pins_q;
  pins_t            pins_nxt;
  logic [LANES-1:0] dqm_q;
  logic [LANES-1:0] dqm_nxt;
  logic             cke_q;
  logic             adv;
  logic             wr_due;
  logic             rd_now;

  // an edge is valid only if clock enable was high on the pins before it
  assign adv = cke_q;

  sdram_addr_map #(.ORG(ORG)) u_map (
    .cmd      (cmd),
    .lin_addr (lin_addr),
    .pre_all  (pre_all),
    .cur      (pins_q),
    .nxt      (pins_nxt)
  );

  sdram_mask_align #(.ORG(ORG), .WR_LAG(2)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .beat    (beat),
    .be      (be),
    .dqm_nxt (dqm_nxt),
    .wr_due  (wr_due),
    .rd_now  (rd_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pins_q <= '{a: '0, ba: '0, cs_n: 1'b1};
      dqm_q  <= '1;
      cke_q  <= 1'b1;
    end else begin
      cke_q <= cke_req;
      if (adv) begin
        pins_q <= pins_nxt;
        dqm_q  <= dqm_nxt;
      end
    end
  end

  assign sd_addr = pins_q.a;
  assign sd_bank = pins_q.ba;
  assign sd_cs_n = pins_q.cs_n;
  assign sd_cke  = cke_q;
  assign sd_dqm  = dqm_q;

endmodule

// File: rtl/sdram_pin_driver_chk.sv
module sdram_pin_driver_chk
  import sdram_drv_pkg::*;
#(
  parameter  int ORG   = 0,
  localparam int COL_W = col_width(ORG),
  localparam int LIN_W = COL_W + BANK_W + ROW_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd,
  input logic [LIN_W-1:0]  lin_addr,
  input logic              pre_all,
  input logic [1:0]        beat,
  input logic [LANES-1:0]  be,
  input logic              cke_req,
  input logic [PIN_W-1:0]  sd_addr,
  input logic [BANK_W-1:0] sd_bank,
  input logic              sd_cs_n,
  input logic              sd_cke,
  input logic [LANES-1:0]  sd_dqm
);

  p_act_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sd_cke) && $past(cmd) == 3'd1)
      |-> (sd_addr == $past(lin_addr[LIN_W-1 -: ROW_W]) && !sd_cs_n));

  p_bank_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sd_cke) && $past(cmd) != 3'd0)
      |-> sd_bank == $past(lin_addr[COL_W +: BANK_W]));

  p_col_upper_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sd_cke) && ($past(cmd) == 3'd2 || $past(cmd) == 3'd3))
      |-> ((sd_addr >> COL_W) == '0));

  p_pre_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sd_cke) && $past(cmd) == 3'd4)
      |-> (sd_addr[AP_POS] == $past(pre_all) && (sd_addr & ~(PIN_W'(1) << AP_POS)) == '0));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sd_cke) && $past(cmd) == 3'd0)
      |-> (sd_cs_n && $stable(sd_addr) && $stable(sd_bank)));

  p_wr_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 3) && $past(rst_n, 2) && $past(rst_n) &&
     $past(sd_cke, 3) && $past(sd_cke, 2) && $past(sd_cke) && $past(beat, 3) == 2'd2)
      |-> sd_dqm == lane_mask(ORG == 0, $past(be, 3)));

  p_cke_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> sd_cke == $past(cke_req));

  p_suspend_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(sd_cke))
      |-> ($stable(sd_addr) && $stable(sd_bank) && $stable(sd_cs_n) && $stable(sd_dqm)));

endmodule

bind sdram_pin_driver sdram_pin_driver_chk #(.ORG(ORG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd      (cmd),
  .lin_addr (lin_addr),
  .pre_all  (pre_all),
  .beat     (beat),
  .be       (be),
  .cke_req  (cke_req),
  .sd_addr  (sd_addr),
  .sd_bank  (sd_bank),
  .sd_cs_n  (sd_cs_n),
  .sd_cke   (sd_cke),
  .sd_dqm   (sd_dqm)
);

// File: tb/sdram_pin_driver_tb.sv
`timescale 1ns/1ps
module sdram_pin_driver_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [23:0] addr = '0;
  logic        pre_all = 1'b0;
  logic [1:0]  beat = 2'd0;
  logic [1:0]  be = 2'b00;
  logic        cke_req = 1'b1;

  logic [11:0] a0, a1, a2;
  logic [1:0]  b0, b1, b2;
  logic        cs0, cs1, cs2;
  logic        ck0, ck1, ck2;
  logic [1:0]  m0, m1, m2;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sdram_pin_driver #(.ORG(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .lin_addr(addr[21:0]), .pre_all(pre_all),
    .beat(beat), .be(be), .cke_req(cke_req),
    .sd_addr(a0), .sd_bank(b0), .sd_cs_n(cs0), .sd_cke(ck0), .sd_dqm(m0));

  sdram_pin_driver #(.ORG(1)) u_dut_x8 (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .lin_addr(addr[22:0]), .pre_all(pre_all),
    .beat(beat), .be(be), .cke_req(cke_req),
    .sd_addr(a1), .sd_bank(b1), .sd_cs_n(cs1), .sd_cke(ck1), .sd_dqm(m1));

  sdram_pin_driver #(.ORG(2)) u_dut_x4 (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .lin_addr(addr[23:0]), .pre_all(pre_all),
    .beat(beat), .be(be), .cke_req(cke_req),
    .sd_addr(a2), .sd_bank(b2), .sd_cs_n(cs2), .sd_cke(ck2), .sd_dqm(m2));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(logic [2:0] c, logic [23:0] ad, logic pa, logic [1:0] bt,
                       logic [1:0] en, logic ck);
    cmd = c; addr = ad; pre_all = pa; beat = bt; be = en; cke_req = ck;
  endtask

  task automatic quiet(int n);
    drive(3'd0, addr, 1'b0, 2'd0, 2'b00, 1'b1);
    for (int i = 0; i < n; i++) tick();
  endtask

  // independent field arithmetic: column width 8 + org
  function automatic int cw(int d);
    return 8 + d;
  endfunction
  function automatic logic [11:0] row_of(int d, logic [23:0] ad);
    return 12'((ad >> (cw(d) + 2)) & 24'hFFF);
  endfunction
  function automatic logic [1:0] bank_of(int d, logic [23:0] ad);
    return 2'((ad >> cw(d)) & 24'h3);
  endfunction
  function automatic logic [11:0] col_of(int d, logic [23:0] ad);
    return 12'(ad & ((24'h1 << cw(d)) - 24'h1));
  endfunction
  function automatic logic [1:0] exp_mask(int d, logic [1:0] en);
    if (d == 0) return {~en[1], ~en[0]};
    return en[0] ? 2'b00 : 2'b11;
  endfunction

  task automatic chk_pins(string req, int d, logic [11:0] ea, logic [1:0] eb, logic ecs);
    logic [11:0] aa; logic [1:0] bb; logic cc;
    case (d)
      0: begin aa = a0; bb = b0; cc = cs0; end
      1: begin aa = a1; bb = b1; cc = cs1; end
      default: begin aa = a2; bb = b2; cc = cs2; end
    endcase
    chk(req, $sformatf("org%0d addr", d), 32'(aa), 32'(ea));
    chk(req, $sformatf("org%0d bank", d), 32'(bb), 32'(eb));
    chk(req, $sformatf("org%0d cs_n", d), 32'(cc), 32'(ecs));
  endtask

  task automatic chk_dqm(string req, int d, logic [1:0] e);
    logic [1:0] mm;
    case (d)
      0: mm = m0;
      1: mm = m1;
      default: mm = m2;
    endcase
    chk(req, $sformatf("org%0d dqm", d), 32'(mm), 32'(e));
  endtask

  task automatic t_reset();
    for (int d = 0; d < 3; d++) begin
      chk_pins("R1", d, 12'h000, 2'b00, 1'b1);
      chk_dqm("R1", d, 2'b11);
    end
    chk("R1", "cke", {29'd0, ck0, ck1, ck2}, 32'h7);
  endtask

  task automatic t_activate();
    logic [23:0] pats [3] = '{24'hA5C3F1, 24'h3FFFFF, 24'h5A0C37};
    foreach (pats[i]) begin
      drive(3'd1, pats[i], 1'b0, 2'd0, 2'b00, 1'b1);
      tick();
      for (int d = 0; d < 3; d++)
        chk_pins("R2 R3", d, row_of(d, pats[i]), bank_of(d, pats[i]), 1'b0);
    end
    quiet(1);
  endtask

  task automatic t_rdwr();
    drive(3'd2, 24'hFFFFFF, 1'b0, 2'd0, 2'b00, 1'b1);
    tick();
    for (int d = 0; d < 3; d++)
      chk_pins("R4", d, col_of(d, 24'hFFFFFF), 2'b11, 1'b0);
    drive(3'd3, 24'h5A5A5A, 1'b0, 2'd0, 2'b00, 1'b1);
    tick();
    for (int d = 0; d < 3; d++)
      chk_pins("R4", d, col_of(d, 24'h5A5A5A), bank_of(d, 24'h5A5A5A), 1'b0);
    quiet(1);
  endtask

  task automatic t_precharge();
    drive(3'd4, 24'hFFFFFF, 1'b1, 2'd0, 2'b00, 1'b1);
    tick();
    for (int d = 0; d < 3; d++) chk_pins("R5", d, 12'h400, 2'b11, 1'b0);
    drive(3'd4, 24'h123456, 1'b0, 2'd0, 2'b00, 1'b1);
    tick();
    for (int d = 0; d < 3; d++) chk_pins("R5", d, 12'h000, bank_of(d, 24'h123456), 1'b0);
    quiet(1);
  endtask

  task automatic t_idle();
    drive(3'd1, 24'hC3A96E, 1'b0, 2'd0, 2'b00, 1'b1);
    tick();
    drive(3'd0, 24'h000000, 1'b0, 2'd0, 2'b00, 1'b1);
    tick();
    for (int d = 0; d < 3; d++)
      chk_pins("R6", d, row_of(d, 24'hC3A96E), bank_of(d, 24'hC3A96E), 1'b1);
  endtask

  task automatic t_rd_mask();
    drive(3'd0, 24'h0, 1'b0, 2'd1, 2'b01, 1'b1);
    tick();
    for (int d = 0; d < 3; d++) chk_dqm("R7 R9", d, exp_mask(d, 2'b01));
    drive(3'd0, 24'h0, 1'b0, 2'd1, 2'b10, 1'b1);
    tick();
    for (int d = 0; d < 3; d++) chk_dqm("R7 R9", d, exp_mask(d, 2'b10));
    quiet(1);
    for (int d = 0; d < 3; d++) chk_dqm("R10 idle mask", d, 2'b11);
  endtask

  task automatic t_wr_mask();
    drive(3'd0, 24'h0, 1'b0, 2'd2, 2'b01, 1'b1);
    tick();
    for (int d = 0; d < 3; d++) chk_dqm("R8 lag0", d, 2'b11);
    quiet(1);
    for (int d = 0; d < 3; d++) chk_dqm("R8 lag1", d, 2'b11);
    tick();
    for (int d = 0; d < 3; d++) chk_dqm("R8 R9", d, exp_mask(d, 2'b01));
    quiet(2);
  endtask

  task automatic t_collide();
    drive(3'd0, 24'h0, 1'b0, 2'd2, 2'b01, 1'b1);
    tick();
    quiet(1);
    drive(3'd0, 24'h0, 1'b0, 2'd1, 2'b10, 1'b1);
    tick();
    for (int d = 0; d < 3; d++) chk_dqm("R10 write wins", d, exp_mask(d, 2'b01));
    quiet(3);
  endtask

  task automatic t_suspend();
    drive(3'd1, 24'h9E4B27, 1'b0, 2'd2, 2'b10, 1'b0);
    tick();
    chk("R11", "cke low", {29'd0, ck0, ck1, ck2}, 32'h0);
    for (int d = 0; d < 3; d++) chk_pins("R12 pre", d, row_of(d, 24'h9E4B27), bank_of(d, 24'h9E4B27), 1'b0);
    drive(3'd4, 24'hFFFFFF, 1'b1, 2'd1, 2'b00, 1'b1);
    tick();
    chk("R11", "cke high", {29'd0, ck0, ck1, ck2}, 32'h7);
    for (int d = 0; d < 3; d++) begin
      chk_pins("R12 dropped", d, row_of(d, 24'h9E4B27), bank_of(d, 24'h9E4B27), 1'b0);
      chk_dqm("R12 dropped", d, 2'b11);
    end
    quiet(1);
    for (int d = 0; d < 3; d++) chk_dqm("R12 frozen lag", d, 2'b11);
    tick();
    for (int d = 0; d < 3; d++) chk_dqm("R12 R8 late mask", d, exp_mask(d, 2'b10));
    quiet(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    quiet(2);
    t_activate();
    t_rdwr();
    t_precharge();
    t_idle();
    t_rd_mask();
    t_wr_mask();
    t_collide();
    t_suspend();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule